// File: doc/BRIEF.md
# Receive Buffer Slot Manager

This block hands received Ethernet frames to host memory through a small ring of four buffer slots that software refills. Each slot holds a state, a buffer base address and a byte count. Software gives a buffer back to the hardware by writing its address and then setting its state to loaded. When an upstream receiver presents a finished frame, the manager picks the lowest-numbered loaded slot and asks an external DMA engine to write the frame to that slot's address. When the DMA engine reports completion, the manager stores the frame length in the slot's count field, marks the slot pending and pulses a receive interrupt for one clock.

The control state machine has two states. In `FS_IDLE` the block can take a frame. The transition *take* (`FS_IDLE` to `FS_XFER`) fires when a frame is presented, receive reset is clear and some slot is loaded. The *drop* self-loop stays in `FS_IDLE`; it fires when a frame is presented while receive reset is set or while no slot is loaded. In `FS_XFER` the DMA request is held. The transition *commit* (`FS_XFER` to `FS_IDLE`) fires when the DMA engine signals done, and the slot is updated on that same edge. The slot index, buffer address and length are captured at *take*, so host activity during a transfer cannot redirect the frame.

Registers sit on a word-addressed bus with combinational read data:
- Word 0 bit 0 is receive reset.
- Slot i occupies words 4·(i+1) to 4·(i+1)+2, holding its state, its address and its count in that order.
- Every other word reads as zero and ignores writes.

Top module: `rxslot_mgr`

## Requirements
- R1: After reset every register reads zero, and `frm_ready`, `dma_req` and `rx_irq` are low.
- R2: Word 0 bit 0 holds receive reset. Slot i's state, address and count are read and written at words 4·(i+1), 4·(i+1)+1 and 4·(i+1)+2. State codes are 0 empty, 1 loaded and 2 pending, and a write stores the low two bits.
- R3: A frame presented in `FS_IDLE`, with receive reset clear and a slot loaded, goes to the lowest-numbered loaded slot. From the next cycle `dma_req` is high, with `dma_addr` equal to that slot's address and `dma_len` equal to the frame length, and it stays high until `dma_done`.
- R4: The slot, the address and the length are captured when the frame is taken. Host writes during the transfer do not change `dma_addr` or the slot that is updated.
- R5: On the edge where `dma_done` is seen with `dma_req` high, the slot's count becomes the frame length and its state becomes 2. `rx_irq` is then high for exactly the next cycle.
- R6: A frame presented while no slot is loaded is dropped: no DMA request, no interrupt and no slot change.
- R7: While receive reset is set, every frame is dropped, even if slots are loaded.
- R8: `frm_ready` is high exactly when the state is `FS_IDLE` and either receive reset is set or some slot is loaded.
- R9: Reads of unmapped words return zero, and writes to them change no register.
- R10: Frames presented during `FS_XFER` are ignored.
- R11: If the host writes the state or count of the slot being committed in the same cycle as the commit, the commit's values win.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data (combinational) |
| frm_valid | input | 1 | A received frame is presented this cycle |
| frm_len | input | LEN_W | Byte length of the presented frame |
| frm_ready | output | 1 | Upstream flow-control indication |
| dma_req | output | 1 | DMA write request, held until done |
| dma_addr | output | DMA_AW | Buffer address for the DMA write |
| dma_len | output | LEN_W | Byte length for the DMA write |
| dma_done | input | 1 | DMA engine reports completion |
| rx_irq | output | 1 | One-cycle receive interrupt pulse |

## Verification
Assertions check the following on every cycle:
- the DMA request and its address stay unchanged until done;
- the interrupt is a single-cycle pulse that follows a commit;
- a commit leaves the slot pending with the captured length, even against a same-cycle host write;
- a frame presented under receive reset or with no loaded slot starts no transfer;
- a setup write lands in the reset bit.

Only the bench scenarios can show the remaining behaviours: that the lowest loaded slot is the one chosen, that address changes during a transfer do not redirect the frame, that unmapped words stay zero, and that frames arriving mid-transfer leave no trace in the registers. The bench's behavioural model tracks these across the whole run.

// File: rtl/rxslot_pkg.sv
package rxslot_pkg;

    typedef enum logic [1:0] {
        SLOT_EMPTY   = 2'd0,
        SLOT_LOADED  = 2'd1,
        SLOT_PENDING = 2'd2
    } slot_state_e;

    typedef enum logic [0:0] {
        FS_IDLE = 1'b0,
        FS_XFER = 1'b1
    } fsm_state_e;

    localparam logic [1:0] FLD_STATE = 2'd0;
    localparam logic [1:0] FLD_ADDR  = 2'd1;
    localparam logic [1:0] FLD_COUNT = 2'd2;

endpackage

// File: rtl/rxslot_entry.sv
module rxslot_entry
    import rxslot_pkg::*;
#(
    parameter int AW = 32,
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_state,
    input  logic          wr_addr,
    input  logic          wr_count,
    input  logic [1:0]    wd_state,
    input  logic [AW-1:0] wd_addr,
    input  logic [LW-1:0] wd_count,
    input  logic          commit,
    input  logic [LW-1:0] commit_len,
    output logic [1:0]    state,
    output logic [AW-1:0] addr,
    output logic [LW-1:0] count
);

    // hardware commit has priority over a host write in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= SLOT_EMPTY;
            count <= '0;
        end else if (commit) begin
            state <= SLOT_PENDING;
            count <= commit_len;
        end else begin
            if (wr_state) state <= wd_state;
            if (wr_count) count <= wd_count;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       addr <= '0;
        else if (wr_addr) addr <= wd_addr;
    end

    // R5 and R11: the commit leaves the slot pending with the captured length
    a_r11_commit_wins: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (state == SLOT_PENDING && count == $past(commit_len)));

endmodule

// File: rtl/rxslot_pick.sv
module rxslot_pick #(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input  logic [N-1:0]     loaded,
    output logic             any,
    output logic [IDX_W-1:0] idx
);

    // scanning downward leaves the lowest loaded index last
    always_comb begin
        any = |loaded;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (loaded[i]) idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/rxslot_fsm.sv
module rxslot_fsm
    import rxslot_pkg::*;
#(
    parameter int IDX_W  = 2,
    parameter int DMA_AW = 32,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frm_valid,
    input  logic [LEN_W-1:0]  frm_len,
    input  logic              rx_rst,
    input  logic              any_loaded,
    input  logic [IDX_W-1:0]  pick_idx,
    input  logic [DMA_AW-1:0] pick_addr,
    input  logic              dma_done,
    output logic              frm_ready,
    output logic              dma_req,
    output logic [DMA_AW-1:0] dma_addr,
    output logic [LEN_W-1:0]  dma_len,
    output logic              commit,
    output logic [IDX_W-1:0]  commit_idx,
    output logic              rx_irq
);

    fsm_state_e st, st_nx;
    logic       take;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= FS_IDLE;
        else        st <= st_nx;
    end

    // transitions: take, drop (self-loop), commit
    always_comb begin
        st_nx = st;
        take  = 1'b0;
        unique case (st)
            FS_IDLE: begin
                if (frm_valid && !rx_rst && any_loaded) begin
                    take  = 1'b1;
                    st_nx = FS_XFER;
                end
            end
            FS_XFER: begin
                if (dma_done) st_nx = FS_IDLE;
            end
            default: st_nx = FS_IDLE;
        endcase
    end

    // outputs: capture the slot at take, pulse the interrupt at commit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            commit_idx <= '0;
            dma_addr   <= '0;
            dma_len    <= '0;
            rx_irq     <= 1'b0;
        end else begin
            if (take) begin
                commit_idx <= pick_idx;
                dma_addr   <= pick_addr;
                dma_len    <= frm_len;
            end
            rx_irq <= commit;
        end
    end

    assign dma_req   = (st == FS_XFER);
    assign commit    = dma_req && dma_done;
    assign frm_ready = (st == FS_IDLE) && (rx_rst || any_loaded);

    a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && !dma_done) |=> dma_req);

    a_r4_target_held: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && !dma_done) |=> ($stable(dma_addr) && $stable(commit_idx) && $stable(dma_len)));

    a_r5_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |=> !rx_irq);

    a_r5_irq_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> !dma_req);

    a_r7_reset_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (!dma_req && frm_valid && rx_rst) |=> !dma_req);

    a_r6_empty_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (!dma_req && frm_valid && !any_loaded) |=> !dma_req);

endmodule

// File: rtl/rxslot_mgr.sv
module rxslot_mgr
    import rxslot_pkg::*;
#(
    parameter int N_SLOTS = 4,
    parameter int ADDR_W  = 5,
    parameter int DATA_W  = 32,
    parameter int DMA_AW  = 32,
    parameter int LEN_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              frm_valid,
    input  logic [LEN_W-1:0]  frm_len,
    output logic              frm_ready,
    output logic              dma_req,
    output logic [DMA_AW-1:0] dma_addr,
    output logic [LEN_W-1:0]  dma_len,
    input  logic              dma_done,
    output logic              rx_irq
);

    localparam int IDX_W = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1;
    localparam int GW    = ADDR_W - 2;

    logic [GW-1:0]     grp;
    logic [1:0]        fld;
    logic              rx_rst;
    logic [1:0]        st_a  [N_SLOTS];
    logic [DMA_AW-1:0] adr_a [N_SLOTS];
    logic [LEN_W-1:0]  cnt_a [N_SLOTS];
    logic [N_SLOTS-1:0] loaded;
    logic              any_loaded;
    logic [IDX_W-1:0]  pick_idx;
    logic              commit;
    logic [IDX_W-1:0]  commit_idx;

    assign grp = reg_addr[ADDR_W-1:2];
    assign fld = reg_addr[1:0];

    // setup word: only the receive-reset bit is stored
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                             rx_rst <= 1'b0;
        else if (reg_wr && grp == '0 && fld == FLD_STATE) rx_rst <= reg_wdata[0];
    end

    for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
        logic hit;
        assign hit = reg_wr && (grp == GW'(g + 1));

        rxslot_entry #(.AW(DMA_AW), .LW(LEN_W)) u_entry (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_state   (hit && fld == FLD_STATE),
            .wr_addr    (hit && fld == FLD_ADDR),
            .wr_count   (hit && fld == FLD_COUNT),
            .wd_state   (reg_wdata[1:0]),
            .wd_addr    (reg_wdata[DMA_AW-1:0]),
            .wd_count   (reg_wdata[LEN_W-1:0]),
            .commit     (commit && commit_idx == IDX_W'(g)),
            .commit_len (dma_len),
            .state      (st_a[g]),
            .addr       (adr_a[g]),
            .count      (cnt_a[g])
        );

        assign loaded[g] = (st_a[g] == SLOT_LOADED);
    end

    rxslot_pick #(.N(N_SLOTS), .IDX_W(IDX_W)) u_pick (
        .loaded (loaded),
        .any    (any_loaded),
        .idx    (pick_idx)
    );

    rxslot_fsm #(.IDX_W(IDX_W), .DMA_AW(DMA_AW), .LEN_W(LEN_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .frm_valid  (frm_valid),
        .frm_len    (frm_len),
        .rx_rst     (rx_rst),
        .any_loaded (any_loaded),
        .pick_idx   (pick_idx),
        .pick_addr  (adr_a[pick_idx]),
        .dma_done   (dma_done),
        .frm_ready  (frm_ready),
        .dma_req    (dma_req),
        .dma_addr   (dma_addr),
        .dma_len    (dma_len),
        .commit     (commit),
        .commit_idx (commit_idx),
        .rx_irq     (rx_irq)
    );

    // read decode: unmapped words return zero (R9)
    always_comb begin
        reg_rdata = '0;
        if (grp == '0 && fld == FLD_STATE) reg_rdata = DATA_W'(rx_rst);
        for (int i = 0; i < N_SLOTS; i++) begin
            if (grp == GW'(i + 1)) begin
                unique case (fld)
                    FLD_STATE: reg_rdata = DATA_W'(st_a[i]);
                    FLD_ADDR:  reg_rdata = DATA_W'(adr_a[i]);
                    FLD_COUNT: reg_rdata = DATA_W'(cnt_a[i]);
                    default:   reg_rdata = '0;
                endcase
            end
        end
    end

    a_r2_setup_write: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == '0) |=> (rx_rst == $past(reg_wdata[0])));

    a_r8_ready_needs_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_ready && !rx_rst) |-> (loaded != '0));

endmodule

// File: tb/sim_rxslot_mgr.sv
module sim_rxslot_mgr;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        frm_valid = 1'b0;
    logic [15:0] frm_len = '0;
    logic        frm_ready;
    logic        dma_req;
    logic [31:0] dma_addr;
    logic [15:0] dma_len;
    logic        dma_done = 1'b0;
    logic        rx_irq;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;   // 20 ns period, 50 MHz

    rxslot_mgr u0 (
        .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
        .frm_valid, .frm_len, .frm_ready, .dma_req, .dma_addr, .dma_len,
        .dma_done, .rx_irq
    );

    // behavioural reference model
    int          m_st [4];
    logic [31:0] m_ad [4];
    int          m_cn [4];
    bit          m_rst, m_xfer, m_irq;
    int          m_idx, m_len;
    logic [31:0] m_daddr;

    function automatic logic [31:0] mread(input logic [4:0] a);
        int g = int'(a[4:2]);
        int f = int'(a[1:0]);
        if (g == 0 && f == 0) return {31'b0, m_rst};
        if (g >= 1 && g <= 4) begin
            if (f == 0) return 32'(m_st[g-1]);
            if (f == 1) return m_ad[g-1];
            if (f == 2) return 32'(m_cn[g-1]);
        end
        return 32'h0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) begin m_st[i] = 0; m_ad[i] = 0; m_cn[i] = 0; end
            m_rst = 0; m_xfer = 0; m_irq = 0; m_idx = 0; m_len = 0; m_daddr = 0;
        end else begin
            bit cm;
            bit tk;
            int pick;
            logic [31:0] paddr;
            int g, f;
            cm = m_xfer && dma_done;
            pick = -1;
            for (int i = 0; i < 4; i++) if (pick < 0 && m_st[i] == 1) pick = i;
            tk = !m_xfer && frm_valid && !m_rst && pick >= 0;
            paddr = (pick >= 0) ? m_ad[pick] : 32'h0;
            if (reg_wr) begin
                g = int'(reg_addr[4:2]);
                f = int'(reg_addr[1:0]);
                if (g == 0 && f == 0) m_rst = reg_wdata[0];
                else if (g >= 1 && g <= 4) begin
                    if (f == 0) m_st[g-1] = int'(reg_wdata[1:0]);
                    if (f == 1) m_ad[g-1] = reg_wdata;
                    if (f == 2) m_cn[g-1] = int'(reg_wdata[15:0]);
                end
            end
            if (cm) begin m_st[m_idx] = 2; m_cn[m_idx] = m_len; m_xfer = 0; end
            if (tk) begin m_xfer = 1; m_idx = pick; m_daddr = paddr; m_len = int'(frm_len); end
            m_irq = cm;
        end
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // compare against the model on every cycle, away from the active edge
    always @(negedge clk) begin
        #2;
        if (rst_n && !finished) begin
            bit any;
            any = 0;
            for (int i = 0; i < 4; i++) if (m_st[i] == 1) any = 1;
            chk("R8 frm_ready", {31'b0, frm_ready}, {31'b0, !m_xfer && (m_rst || any)});
            chk("R3 dma_req", {31'b0, dma_req}, {31'b0, m_xfer});
            if (m_xfer) begin
                chk("R4 dma_addr", dma_addr, m_daddr);
                chk("R3 dma_len", {16'b0, dma_len}, 32'(m_len));
            end
            chk("R5 rx_irq", {31'b0, rx_irq}, {31'b0, m_irq});
            chk("R2 reg_rdata", reg_rdata, mread(reg_addr));
        end
    end

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk); reg_addr = a;
        #3 chk(tag, reg_rdata, exp);
    endtask

    task automatic frame(input int len);
        @(negedge clk); frm_valid = 1'b1; frm_len = 16'(len);
        @(negedge clk); frm_valid = 1'b0;
    endtask

    task automatic done();
        @(negedge clk); dma_done = 1'b1;
        @(negedge clk); dma_done = 1'b0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #3;
        // R1 reset state
        chk("R1 frm_ready", {31'b0, frm_ready}, 32'h0);
        chk("R1 dma_req", {31'b0, dma_req}, 32'h0);
        chk("R1 rx_irq", {31'b0, rx_irq}, 32'h0);
        rd(5'd0, 32'h0, "R1 setup");
        rd(5'd4, 32'h0, "R1 slot0 state");
        rd(5'd9, 32'h0, "R1 slot1 addr");
        rd(5'd18, 32'h0, "R1 slot3 count");

        // R6 no slot loaded: frame dropped
        frame(80);
        #3 chk("R6 no dma", {31'b0, dma_req}, 32'h0);
        @(negedge clk); #3 chk("R6 no irq", {31'b0, rx_irq}, 32'h0);
        rd(5'd4, 32'h0, "R6 slot0 unchanged");

        // load slots 1 and 2
        wr(5'd9, 32'h1000_0000);
        wr(5'd8, 32'd1);
        wr(5'd13, 32'h2000_0000);
        wr(5'd12, 32'd1);
        rd(5'd8, 32'd1, "R2 slot1 state");
        rd(5'd13, 32'h2000_0000, "R2 slot2 addr");
        chk("R8 ready with slot", {31'b0, frm_ready}, 32'h1);

        // R3 lowest loaded slot (slot1) chosen
        frame(100);
        #3 chk("R3 req", {31'b0, dma_req}, 32'h1);
        chk("R3 addr slot1", dma_addr, 32'h1000_0000);
        chk("R3 len", {16'b0, dma_len}, 32'd100);
        // R10 frame during transfer ignored; R4 host edits do not redirect
        frame(200);
        wr(5'd5, 32'h4000_0000);
        wr(5'd4, 32'd1);
        wr(5'd9, 32'h3000_0000);
        #3 chk("R4 addr held", dma_addr, 32'h1000_0000);
        chk("R10 len held", {16'b0, dma_len}, 32'd100);
        // R11 host count write in the commit cycle loses
        @(negedge clk); dma_done = 1'b1; reg_wr = 1'b1; reg_addr = 5'd10; reg_wdata = 32'h55;
        @(negedge clk); dma_done = 1'b0; reg_wr = 1'b0;
        #3 chk("R5 irq pulse", {31'b0, rx_irq}, 32'h1);
        @(negedge clk); #3 chk("R5 irq single", {31'b0, rx_irq}, 32'h0);
        chk("R10 no second transfer", {31'b0, dma_req}, 32'h0);
        rd(5'd10, 32'd100, "R11 count from commit");
        rd(5'd8, 32'd2, "R5 slot1 pending");
        rd(5'd9, 32'h3000_0000, "R2 slot1 addr rewritten");
        rd(5'd4, 32'd1, "R4 slot0 still loaded");

        // R3 priority: slot0 now lowest loaded
        frame(64);
        #3 chk("R3 addr slot0", dma_addr, 32'h4000_0000);
        repeat (3) @(negedge clk);
        done();
        rd(5'd4, 32'd2, "R3 slot0 pending");
        rd(5'd6, 32'd64, "R5 slot0 count");

        // R7 receive reset drops frames
        wr(5'd0, 32'h1);
        frame(90);
        #3 chk("R7 no dma", {31'b0, dma_req}, 32'h0);
        chk("R8 ready under reset", {31'b0, frm_ready}, 32'h1);
        rd(5'd12, 32'd1, "R7 slot2 still loaded");
        chk("R7 no irq", {31'b0, rx_irq}, 32'h0);
        wr(5'd0, 32'h0);

        // R9 unmapped words
        wr(5'd1, 32'hFFFF_FFFF);
        rd(5'd1, 32'h0, "R9 word1");
        wr(5'd7, 32'h0000_ABCD);
        rd(5'd7, 32'h0, "R9 word7");
        wr(5'd24, 32'd5);
        rd(5'd24, 32'h0, "R9 word24");
        rd(5'd0, 32'h0, "R9 setup unchanged");
        rd(5'd12, 32'd1, "R9 slot2 unchanged");

        // last loaded slot, then none left
        frame(1530);
        #3 chk("R3 addr slot2", dma_addr, 32'h2000_0000);
        done();
        rd(5'd14, 32'd1530, "R5 slot2 count");
        chk("R8 ready low when none", {31'b0, frm_ready}, 32'h0);
        frame(70);
        #3 chk("R6 drop when none", {31'b0, dma_req}, 32'h0);
        wr(5'd8, 32'd1);
        #3 chk("R8 ready after reload", {31'b0, frm_ready}, 32'h1);
        repeat (2) @(negedge clk);

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule